// File: doc/BRIEF.md
# Autovectored Interrupt Controller

This block gathers fifty-seven interrupt requests for a processor core and reduces them to one request level. Sources 0 to 48 are internal, level-sensitive lines. Sources 49 to 56 come from eight general-purpose pins, with pin p being source 49+p. Each pin passes through a two-stage synchronizer and an edge detector, and a detected edge latches a sticky pending bit.

Every source has an enable bit and a 3-bit priority level. The block outputs the highest level found among the sources that are enabled and requesting. The vector is computed from that level alone: it is a fixed base plus the level, so no per-source vector table exists.

The core acknowledges at a level, and that clears the pending pins programmed to that level. Software can also clear a single pin through a write-one-to-clear access on a small write port.

Top module: `avic_top`

## Requirements
- R1: After reset every level, enable bit, polarity bit and pending bit is zero, `irq_level` reads 0 and `irq_vector` reads 24.
- R2: An internal source i (0..48) requests for as long as `irq_int[i]` is high. Its contribution to `irq_level` appears and disappears in the same cycle as the input, with no register in between.
- R3: A source with enable 0 or level 0 never raises `irq_level`.
- R4: `irq_level` equals the largest level among sources that are enabled and requesting, and equals 0 when there are none.
- R5: `irq_vector` always equals 24 plus `irq_level`.
- R6: A pin transition sampled at rising clock edge k sets the pending bit of that pin at edge k+2, so it is visible from just after that edge.
- R7: Polarity bit 0 (the reset value) selects rising-edge detection and 1 selects falling-edge detection. An edge of the other direction is ignored.
- R8: A pin's pending bit stays set after the pin returns to its idle value, until it is cleared.
- R9: An acknowledge (`ack_valid` high with a nonzero `ack_level`) clears, at the next edge, the pending bits of every pin whose programmed level equals `ack_level`. It leaves pins at other levels and all internal sources unchanged.
- R10: A clear write clears one pin's pending bit at the next edge. When an edge is detected in the same cycle as a clear from a write or an acknowledge, the new edge wins and the bit stays set.
- R11: A pin records edges into its pending bit even while disabled, and the request shows on `irq_level` once the source is enabled.
- R12: A write with `wr_en` high takes effect at the next edge. The `wr_sel` field chooses the operation: 0 sets the level of source `wr_idx` to `wr_data`; 1 sets the enable of source `wr_idx` to `wr_data[0]`; 2 sets the polarity of pin `wr_idx` to `wr_data[0]`; 3 with `wr_data[0]`=1 clears the pending bit of pin `wr_idx`. An index out of range is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_int | input | 49 | Internal level-sensitive requests |
| gpio_pin | input | 8 | Asynchronous pin inputs |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write operation select |
| wr_idx | input | 6 | Source or pin index |
| wr_data | input | 3 | Write data |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest pending enabled level |
| irq_vector | output | 8 | Autovector, 24 plus level |

## Verification
The bench measures the exact edge at which a pin edge appears, so that a synchronizer that is one stage short or one stage long shows up as a level arriving a cycle early or late. It drives the edge opposite to the programmed polarity and expects nothing to latch, and it checks that a pulse survives after the pin returns to idle. An acknowledge is given while pins at several levels are pending. A design that matched on the wrong field would clear the wrong pins or touch internal requests. Finally, the bench lands a clear write on the very edge where a new edge latches, and a design that gave the clear priority would lose the interrupt.

// File: rtl/avic_pkg.sv
package avic_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    CFG_LEVEL    = 2'd0,
    CFG_ENABLE   = 2'd1,
    CFG_POLARITY = 2'd2,
    CFG_CLEAR    = 2'd3
  } cfg_sel_e;

  function automatic logic [7:0] autovector(input logic [7:0] base, input lvl_t lvl);
    return base + 8'(lvl);
  endfunction

  function automatic logic edge_seen(input logic now_v, input logic old_v, input logic falling);
    return falling ? (old_v & ~now_v) : (now_v & ~old_v);
  endfunction
endpackage

// File: rtl/avic_cfg_regs.sv
module avic_cfg_regs
  import avic_pkg::*;
#(
  parameter int N_SRC = 57,
  parameter int N_PIN = 8,
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [LVL_W-1:0]            wr_data,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_q,
  output logic [N_SRC-1:0]            en_q,
  output logic [N_PIN-1:0]            pol_q,
  output logic [N_PIN-1:0]            clr_wr
);
  logic lvl_we, en_we, pol_we;
  assign lvl_we = wr_en && (wr_sel == CFG_LEVEL);
  assign en_we  = wr_en && (wr_sel == CFG_ENABLE);
  assign pol_we = wr_en && (wr_sel == CFG_POLARITY);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end else begin
        if (lvl_we && wr_idx == IDX_W'(i)) lvl_q[i] <= wr_data;
        if (en_we && wr_idx == IDX_W'(i))  en_q[i]  <= wr_data[0];
      end
    end
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pol_q[p] <= 1'b0;
      else if (pol_we && wr_idx == IDX_W'(p)) pol_q[p] <= wr_data[0];
    end
    assign clr_wr[p] = wr_en && (wr_sel == CFG_CLEAR) && wr_data[0] && (wr_idx == IDX_W'(p));
  end

  // R12: a level write lands at the next edge
  assert_level_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we && (int'(wr_idx) < N_SRC)) |=> (lvl_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/avic_pin_edge.sv
module avic_pin_edge
  import avic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic falling,
  input  logic clr,
  output logic pend,
  output logic edge_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_evt = edge_seen(sync_q[SYNC_STAGES-1], prev_q, falling);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (edge_evt) pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end

  // R8: pending holds until cleared
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
  // R6: pending only rises after a detected edge
  assert_rise_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(edge_evt));
  // R10: a clear without a new edge drops the bit
  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_evt) |=> !pend);
  // R10: a new edge beats a clear in the same cycle
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pend);
endmodule

// File: rtl/avic_level_arb.sv
module avic_level_arb
  import avic_pkg::*;
#(
  parameter int N_SRC = 57
) (
  input  logic [N_SRC-1:0]            req,
  input  logic [N_SRC-1:0]            en,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  output logic [LVL_W-1:0]            best
);
  always_comb begin
    best = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && en[i] && (lvl[i] > best)) best = lvl[i];
    end
  end
endmodule

// File: rtl/avic_top.sv
module avic_top
  import avic_pkg::*;
#(
  parameter int         N_INT       = 49,
  parameter int         N_PIN       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VEC_BASE    = 8'd24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] irq_int,
  input  logic [N_PIN-1:0] gpio_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [5:0]       wr_idx,
  input  logic [2:0]       wr_data,
  input  logic             ack_valid,
  input  logic [2:0]       ack_level,
  output logic [2:0]       irq_level,
  output logic [7:0]       irq_vector
);
  localparam int N_SRC = N_INT + N_PIN;
  localparam int IDX_W = 6;

  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [N_SRC-1:0]            en_q;
  logic [N_PIN-1:0]            pol_q, clr_wr, ack_clr, pin_pend, pin_edge;

  avic_cfg_regs #(.N_SRC(N_SRC), .N_PIN(N_PIN), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .lvl_q(lvl_q), .en_q(en_q), .pol_q(pol_q), .clr_wr(clr_wr)
  );

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    assign ack_clr[p] = ack_valid && (ack_level != '0) && (lvl_q[N_INT+p] == ack_level);

    avic_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(gpio_pin[p]), .falling(pol_q[p]),
      .clr(clr_wr[p] | ack_clr[p]), .pend(pin_pend[p]), .edge_evt(pin_edge[p])
    );

    // R9: acknowledge at the pin's level removes its pending bit
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[p] && !pin_edge[p]) |=> !pin_pend[p]);
  end

  avic_level_arb #(.N_SRC(N_SRC)) u_arb (
    .req({pin_pend, irq_int}), .en(en_q), .lvl(lvl_q), .best(irq_level)
  );

  assign irq_vector = autovector(VEC_BASE, irq_level);

  for (genvar i = 0; i < N_INT; i++) begin : g_floor
    // R4: an enabled, asserted internal source sets a floor on the output
    assert_int_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_int[i] && en_q[i]) |-> (irq_level >= lvl_q[i]));
  end

  // R3: nothing enabled means no request
  assert_quiet_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_level == '0));
endmodule

// File: tb/avic_top_test.sv
module avic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 49;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] irq_int = '0;
  logic [NP-1:0] gpio_pin = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [5:0] wr_idx = '0;
  logic [2:0] wr_data = '0;
  logic ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic [2:0] irq_level;
  logic [7:0] irq_vector;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  avic_top uut (
    .clk(clk), .rst_n(rst_n), .irq_int(irq_int), .gpio_pin(gpio_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_lvl[NI+NP];
  bit m_en[NI+NP];
  bit m_pol[NP];
  bit m_pend[NP];
  bit h0[NP], h1[NP], h2[NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NI+NP; i++) begin m_lvl[i] = 0; m_en[i] = 0; end
      for (int p = 0; p < NP; p++) begin
        m_pol[p] = 0; m_pend[p] = 0; h0[p] = 0; h1[p] = 0; h2[p] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit ev, cl;
        ev = m_pol[p] ? (h2[p] && !h1[p]) : (h1[p] && !h2[p]);
        cl = (ack_valid && ack_level != 0 && m_lvl[NI+p] == int'(ack_level)) ||
             (wr_en && wr_sel == 2'd3 && wr_data[0] && int'(wr_idx) == p);
        if (ev) m_pend[p] = 1;
        else if (cl) m_pend[p] = 0;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: if (int'(wr_idx) < NI+NP) m_lvl[wr_idx] = int'(wr_data);
          2'd1: if (int'(wr_idx) < NI+NP) m_en[wr_idx] = wr_data[0];
          2'd2: if (int'(wr_idx) < NP) m_pol[wr_idx] = wr_data[0];
          default: ;
        endcase
      end
      for (int p = 0; p < NP; p++) begin
        h2[p] = h1[p]; h1[p] = h0[p]; h0[p] = gpio_pin[p];
      end
    end
  end

  function automatic int model_level();
    int best = 0;
    for (int i = 0; i < NI; i++)
      if (irq_int[i] && m_en[i] && m_lvl[i] > best) best = m_lvl[i];
    for (int p = 0; p < NP; p++)
      if (m_pend[p] && m_en[NI+p] && m_lvl[NI+p] > best) best = m_lvl[NI+p];
    return best;
  endfunction

  // per-cycle comparison against the model (R4 and R5 on every clock)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = model_level();
      checks++;
      if (int'(irq_level) != e || int'(irq_vector) != 24 + e) begin
        errors++;
        $display("FAIL %s model compare: level=%0d vector=%0d expected level=%0d vector=%0d",
                 cur_req, irq_level, irq_vector, e, 24 + e);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: cycles=%0d expected below 20000", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int sel, int idx, int d);
    wr_en = 1; wr_sel = 2'(sel); wr_idx = 6'(idx); wr_data = 3'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic ack(int l);
    ack_valid = 1; ack_level = 3'(l);
    tick();
    ack_valid = 0;
  endtask

  task automatic expect_lvl(string r, int e);
    checks++;
    if (int'(irq_level) != e || int'(irq_vector) != 24 + e) begin
      errors++;
      $display("FAIL %s: level=%0d vector=%0d expected level=%0d vector=%0d",
               r, irq_level, irq_vector, e, 24 + e);
    end
  endtask

  initial begin
    tick(3);
    cur_req = "R1";
    expect_lvl("R1", 0);
    rst_n = 1;
    tick(2);
    expect_lvl("R1", 0);

    cur_req = "R12";
    wr(0, 3, 5);
    wr(1, 3, 1);
    cur_req = "R2";
    irq_int[3] = 1;
    #1 expect_lvl("R2", 5);
    tick();
    expect_lvl("R5", 5);
    irq_int[3] = 0;
    #1 expect_lvl("R2", 0);

    cur_req = "R3";
    wr(1, 10, 1);
    wr(0, 11, 6);
    irq_int[10] = 1; irq_int[11] = 1;
    tick(2);
    expect_lvl("R3", 0);
    irq_int[10] = 0; irq_int[11] = 0;

    cur_req = "R4";
    wr(0, 20, 7); wr(1, 20, 1);
    wr(0, 30, 2); wr(1, 30, 1);
    irq_int[3] = 1; irq_int[20] = 1; irq_int[30] = 1;
    tick();
    expect_lvl("R4", 7);
    irq_int[20] = 0;
    tick();
    expect_lvl("R4", 5);
    irq_int[3] = 0;
    tick();
    expect_lvl("R4", 2);
    irq_int[30] = 0;
    tick();

    cur_req = "R6";
    wr(0, NI+2, 4); wr(1, NI+2, 1);
    gpio_pin[2] = 1;
    tick();
    expect_lvl("R6", 0);
    tick();
    expect_lvl("R6", 0);
    tick();
    expect_lvl("R6", 4);

    cur_req = "R8";
    gpio_pin[2] = 0;
    tick(6);
    expect_lvl("R8", 4);

    cur_req = "R10";
    wr(3, 2, 1);
    expect_lvl("R10", 0);

    cur_req = "R7";
    wr(2, 2, 1);
    gpio_pin[2] = 1;
    tick(4);
    expect_lvl("R7", 0);
    gpio_pin[2] = 0;
    tick(2);
    expect_lvl("R7", 0);
    tick();
    expect_lvl("R7", 4);

    cur_req = "R9";
    wr(0, NI+5, 4); wr(1, NI+5, 1);
    wr(0, NI+6, 3); wr(1, NI+6, 1);
    gpio_pin[5] = 1; gpio_pin[6] = 1;
    tick(2);
    gpio_pin[5] = 0; gpio_pin[6] = 0;
    tick(3);
    expect_lvl("R9", 4);
    irq_int[3] = 1;
    tick();
    expect_lvl("R9", 5);
    ack(4);
    expect_lvl("R9", 5);
    ack(5);
    expect_lvl("R9", 5);
    irq_int[3] = 0;
    tick();
    expect_lvl("R9", 3);
    ack(3);
    expect_lvl("R9", 0);

    cur_req = "R11";
    wr(0, NI+7, 6);
    gpio_pin[7] = 1;
    tick(2);
    gpio_pin[7] = 0;
    tick(3);
    expect_lvl("R11", 0);
    wr(1, NI+7, 1);
    expect_lvl("R11", 6);
    cur_req = "R10";
    wr(3, 7, 1);
    expect_lvl("R10", 0);

    wr(0, NI+0, 2); wr(1, NI+0, 1);
    gpio_pin[0] = 1;
    tick(2);
    wr(3, 0, 1);
    expect_lvl("R10", 2);
    wr(3, 0, 1);
    expect_lvl("R10", 0);
    gpio_pin[0] = 0;
    tick(4);
    expect_lvl("R7", 0);

    finish_run();
  end
endmodule